// File: doc/BRIEF.md
# Indirect Configuration Channel Controller

This block lets software reach a small bank of 32-bit oscillator-setting slots that are not mapped directly into its address space. Software writes the value it wants to send into an outbound data register, then writes a control word. The control word names a function code and a device index, says whether the access is a write or a read, and has a start bit that launches it. One cycle after that control write the engine checks the request, then either updates the addressed slot or copies it into a return data register. It reports the outcome through done and error flags in a status register.

Only function code 1 addresses the oscillator bank, and only device indices below the slot count are valid. Any other request finishes at once with the error flag set and changes nothing. The stored control word never keeps reserved bits or the start bit, so software can read back what it requested without starting a second access. The slot contents drive the block's `osc_o` bus toward the clock generators. Each slot comes out of reset at its own parameter value.

Top module: `cfgch_top`

## Requirements
- R1: After reset the control register reads 0x00100000. Status, outbound data and return data read 0. Slot i holds bits [32*i+31:32*i] of the OSC_RESET parameter.
- R2: Register offsets are return data 0xA0, outbound data 0xA4, control 0xA8 and status 0xAC. Control fields are device [11:0], function [25:20], write flag bit 30 and start bit 31. A control write stores the written value with bits [19:12], [29:26] and 31 forced to 0.
- R3: Any control write clears status to 0 at the clock edge that accepts it, so status reads 0 in the following cycle.
- R4: A control write with bit 31 set runs one transaction at the next clock edge. Status bit 0 (done) is then 1 and is readable two cycles after the write was presented.
- R5: A transaction is valid only if function equals 1 and device is below NUM_OSC. An invalid one sets status to 3 (done and error) and leaves every slot and the return data register unchanged.
- R6: A valid transaction with bit 30 set copies the outbound data register into slot `device`, which appears on `osc_o`. Other slots keep their values.
- R7: A valid transaction with bit 30 clear loads slot `device` into the return data register. The return data register changes only in that case.
- R8: Outbound data reads back as written. Writes to the status offset, the return data offset or unmapped offsets are ignored. Reads from unmapped offsets return 0.
- R9: A control write with bit 31 clear performs no transaction: status stays 0 and no slot changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, valid while a read is requested |
| osc_o | output | 32*NUM_OSC | Oscillator slot contents, slot 0 in the low word |

## Verification
The properties assume that software does not issue another control write, and does not rewrite outbound data, in the cycle right after a start. This is when the transaction executes, so it is the only cycle where a new request could collide with the one in flight. The stimulus keeps to this by following every started control word with a status read or an idle cycle before the next write. Device indices at the slot-count boundary, at the slot count itself and at the field maximum are all driven. Invalid function codes are driven for both reads and writes.

// File: rtl/cfgch_pkg.sv
package cfgch_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned MAX_OSC = 8;

  localparam logic [11:0] OFS_RTN  = 12'h0A0;
  localparam logic [11:0] OFS_OUT  = 12'h0A4;
  localparam logic [11:0] OFS_CTRL = 12'h0A8;
  localparam logic [11:0] OFS_STAT = 12'h0AC;

  localparam int unsigned DEV_LSB = 0;
  localparam int unsigned DEV_W   = 12;
  localparam int unsigned FN_LSB  = 20;
  localparam int unsigned FN_W    = 6;
  localparam int unsigned WR_BIT  = 30;
  localparam int unsigned GO_BIT  = 31;

  localparam logic [DW-1:0]   CTRL_KEEP = 32'h43F0_0FFF;
  localparam logic [DW-1:0]   CTRL_RST  = 32'h0010_0000;
  localparam logic [FN_W-1:0] FN_OSC    = 6'd1;

  typedef struct packed {
    logic slot_we;
    logic rtn_we;
    logic done;
    logic err;
  } xact_t;
endpackage

// File: rtl/cfgch_engine.sv
module cfgch_engine
  import cfgch_pkg::*;
#(
  parameter int unsigned NUM_OSC = 4,
  localparam int unsigned IW = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1
) (
  input  logic          go_i,
  input  logic [DW-1:0] ctrl_i,
  output xact_t         xact_o,
  output logic [IW-1:0] idx_o
);
  logic [DEV_W-1:0] dev;
  logic [FN_W-1:0]  fn;
  logic             ok;

  assign dev = ctrl_i[DEV_LSB +: DEV_W];
  assign fn  = ctrl_i[FN_LSB +: FN_W];
  assign ok  = (fn == FN_OSC) && (32'(dev) < NUM_OSC);

  always_comb begin
    xact_o.done    = go_i;
    xact_o.err     = go_i & ~ok;
    xact_o.slot_we = go_i & ok & ctrl_i[WR_BIT];
    xact_o.rtn_we  = go_i & ok & ~ctrl_i[WR_BIT];
  end

  assign idx_o = dev[IW-1:0];
endmodule

// File: rtl/cfgch_slots.sv
module cfgch_slots
  import cfgch_pkg::*;
#(
  parameter int unsigned NUM_OSC = 4,
  parameter logic [MAX_OSC*DW-1:0] OSC_RESET = '0,
  localparam int unsigned IW = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [IW-1:0]         idx_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rd_o,
  output logic [NUM_OSC*DW-1:0] osc_o
);
  logic [NUM_OSC-1:0][DW-1:0] slot_q;

  for (genvar i = 0; i < NUM_OSC; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          slot_q[i] <= OSC_RESET[i*DW +: DW];
      else if (we_i && idx_i == IW'(i))     slot_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rd_o = '0;
    for (int i = 0; i < NUM_OSC; i++) begin
      if (idx_i == IW'(i)) rd_o = slot_q[i];
    end
  end

  assign osc_o = slot_q;
endmodule

// File: rtl/cfgch_regs.sv
module cfgch_regs
  import cfgch_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  xact_t         xact_i,
  input  logic [DW-1:0] slot_rd_i,
  output logic          go_o,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] out_o,
  output logic [1:0]    stat_o,
  output logic [DW-1:0] rtn_o,
  output logic [DW-1:0] rdata_o
);
  logic ctrl_wr, out_wr;

  assign ctrl_wr = req_i & we_i & (addr_i == AW'(OFS_CTRL));
  assign out_wr  = req_i & we_i & (addr_i == AW'(OFS_OUT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= CTRL_RST;
      out_o  <= '0;
      stat_o <= '0;
      rtn_o  <= '0;
      go_o   <= 1'b0;
    end else begin
      go_o <= ctrl_wr & wdata_i[GO_BIT];
      if (ctrl_wr) ctrl_o <= wdata_i & CTRL_KEEP;
      if (out_wr)  out_o  <= wdata_i;
      // a new control word wins over a completing transaction
      if (ctrl_wr)          stat_o <= '0;
      else if (xact_i.done) stat_o <= {xact_i.err, 1'b1};
      if (xact_i.rtn_we) rtn_o <= slot_rd_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (addr_i)
        AW'(OFS_RTN):  rdata_o = rtn_o;
        AW'(OFS_OUT):  rdata_o = out_o;
        AW'(OFS_CTRL): rdata_o = ctrl_o;
        AW'(OFS_STAT): rdata_o = {30'b0, stat_o};
        default:       rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/cfgch_top.sv
module cfgch_top
  import cfgch_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned NUM_OSC = 4,
  parameter logic [MAX_OSC*DW-1:0] OSC_RESET = '0,
  localparam int unsigned IW = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  output logic [NUM_OSC*32-1:0] osc_o
);
  logic          go_q;
  logic [DW-1:0] ctrl_q, out_q, rtn_q, slot_rd;
  logic [1:0]    stat_q;
  logic [IW-1:0] idx;
  xact_t         xact;

  cfgch_regs #(.AW(AW)) i_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .xact_i(xact), .slot_rd_i(slot_rd),
    .go_o(go_q), .ctrl_o(ctrl_q), .out_o(out_q), .stat_o(stat_q),
    .rtn_o(rtn_q), .rdata_o
  );

  cfgch_engine #(.NUM_OSC(NUM_OSC)) i_engine (
    .go_i(go_q), .ctrl_i(ctrl_q), .xact_o(xact), .idx_o(idx)
  );

  cfgch_slots #(.NUM_OSC(NUM_OSC), .OSC_RESET(OSC_RESET)) i_slots (
    .clk_i, .rst_ni, .we_i(xact.slot_we), .idx_i(idx), .wdata_i(out_q),
    .rd_o(slot_rd), .osc_o
  );
endmodule

// File: rtl/cfgch_chk.sv
module cfgch_chk
  import cfgch_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned NUM_OSC = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [AW-1:0]         addr_i,
  input logic [DW-1:0]         wdata_i,
  input logic [DW-1:0]         ctrl_q,
  input logic [1:0]            stat_q,
  input logic [DW-1:0]         rtn_q,
  input logic [NUM_OSC*DW-1:0] osc_o
);
  logic cw;
  assign cw = req_i & we_i & (addr_i == AW'(OFS_CTRL));

  a_r2_ctrl_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw |=> ctrl_q == ($past(wdata_i) & CTRL_KEEP));

  a_r2_start_never_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[GO_BIT]);

  a_r3_status_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw |=> stat_q == 2'b00);

  a_r4_done_follows_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cw && wdata_i[GO_BIT]) ##1 !cw |=> stat_q[0]);

  a_r9_no_start_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cw && !wdata_i[GO_BIT]) ##1 !cw |=> stat_q == 2'b00);

  a_r5_error_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q[1] |-> stat_q[0]);

  a_r6_slot_change_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(osc_o) |-> (stat_q == 2'b01) && ctrl_q[WR_BIT]);

  a_r7_rtn_change_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rtn_q) |-> (stat_q == 2'b01) && !ctrl_q[WR_BIT]);
endmodule

bind cfgch_top cfgch_chk #(.AW(AW), .NUM_OSC(NUM_OSC)) i_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
  .ctrl_q, .stat_q, .rtn_q, .osc_o
);

// File: tb/test_cfgch_top.sv
module test_cfgch_top;
  localparam int unsigned N = 3;
  localparam logic [255:0] RST_VALS = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
                                       32'h017D_7840, 32'h02FA_F080, 32'h05F5_E100};
  localparam logic [11:0] A_RTN = 12'h0A0, A_OUT = 12'h0A4,
                          A_CTRL = 12'h0A8, A_STAT = 12'h0AC;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N*32-1:0] osc;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          is_slot;
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  cfgch_top #(.AW(12), .NUM_OSC(N), .OSC_RESET(RST_VALS)) i_cfgch_top (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .osc_o(osc)
  );

  // monitor: pops items pushed at this negedge and compares mid-cycle
  always @(negedge clk) begin
    #4;
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = it.is_slot ? osc[it.sel*32 +: 32] : rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; wdata = '0;
    it.is_slot = 1'b0; it.sel = 0; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic slot(input int i, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    it.is_slot = 1'b1; it.sel = i; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  function automatic logic [31:0] rv(input int i);
    return RST_VALS[i*32 +: 32];
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(A_CTRL, 32'h0010_0000, "R1 ctrl reset");
    rd(A_STAT, 32'h0, "R1 status reset");
    rd(A_OUT,  32'h0, "R1 outbound reset");
    rd(A_RTN,  32'h0, "R1 return reset");
    for (int i = 0; i < N; i++) slot(i, rv(i), "R1 slot reset");

    // R2 masking, R9 no start
    wr(A_CTRL, 32'h7FFF_FFFF);
    rd(A_CTRL, 32'h43F0_0FFF, "R2 reserved bits stripped");
    rd(A_STAT, 32'h0, "R9 no transaction without start");
    for (int i = 0; i < N; i++) slot(i, rv(i), "R9 slots untouched");

    // R8 outbound data
    wr(A_OUT, 32'hCAFE_0001);
    rd(A_OUT, 32'hCAFE_0001, "R8 outbound readback");

    // R3/R4/R6 valid write to slot 1
    wr(A_CTRL, 32'hC010_0001);
    rd(A_STAT, 32'h0, "R3 status cleared by control write");
    rd(A_STAT, 32'h1, "R4 done after start");
    rd(A_CTRL, 32'h4010_0001, "R2 start bit not stored");
    slot(1, 32'hCAFE_0001, "R6 slot1 written");
    slot(0, rv(0), "R6 slot0 kept");
    slot(2, rv(2), "R6 slot2 kept");

    // R7 valid reads
    wr(A_CTRL, 32'h8010_0001);
    idle();
    rd(A_RTN, 32'hCAFE_0001, "R7 read slot1");
    rd(A_STAT, 32'h1, "R4 done on read");
    wr(A_CTRL, 32'h8010_0002);
    idle();
    rd(A_RTN, rv(2), "R7 read top slot");

    // R5 device == NUM_OSC on read; R7 return kept
    wr(A_CTRL, 32'h8010_0003);
    idle();
    rd(A_STAT, 32'h3, "R5 device at slot count errors");
    rd(A_RTN, rv(2), "R7 failed read keeps return data");

    // R5 bad function on write
    wr(A_OUT, 32'h1234_5678);
    wr(A_CTRL, 32'hC020_0000);
    idle();
    rd(A_STAT, 32'h3, "R5 bad function errors");
    slot(0, rv(0), "R5 slot0 untouched");

    // R5 max device field
    wr(A_CTRL, 32'hC010_0FFF);
    idle();
    rd(A_STAT, 32'h3, "R5 max device errors");
    for (int i = 0; i < N; i++) slot(i, i == 1 ? 32'hCAFE_0001 : rv(i), "R5 slots untouched");

    // R3/R9 control write clears prior error
    wr(A_CTRL, 32'h0010_0000);
    idle();
    rd(A_STAT, 32'h0, "R3 error cleared by control write");

    // R8 ignored writes and unmapped reads
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_RTN,  32'hFFFF_FFFF);
    wr(12'h100, 32'hFFFF_FFFF);
    rd(A_STAT, 32'h0, "R8 status write ignored");
    rd(A_RTN, rv(2), "R8 return write ignored");
    rd(12'h100, 32'h0, "R8 unmapped read zero");
    rd(A_OUT, 32'h1234_5678, "R8 outbound unaffected");

    // R6 last valid device
    wr(A_OUT, 32'hA5A5_A5A5);
    wr(A_CTRL, 32'hC010_0002);
    idle();
    slot(2, 32'hA5A5_A5A5, "R6 top slot written");
    rd(A_STAT, 32'h1, "R4 done no error");

    idle();
    idle();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule